// File: doc/BRIEF.md
# Hart-local interrupt cause controller

This block is the first-level interrupt controller that sits in front of one processor core. Every interrupt headed for that core passes through it. It collects three sources: a software line used for signalling between processors, a timer line, and an external line driven by the platform-level interrupt controller. Each source has a pending bit and an enable bit. The block raises a single interrupt request when some source is both pending and enabled and the global interrupt enable is high.

Alongside the request it presents an XLEN-wide trap cause word. The top bit of that word is set to mark an interrupt rather than an exception, and the low field carries an architecture-defined code: 1 for software, 5 for timer, 9 for external. When several sources qualify at once, the highest-ranked one wins. While the request stays asserted the cause word does not move, so the core can sample it on any cycle of the request.

Software reaches the enable and pending words through a small register-style port. The enable bits sit at the same bit positions as the cause codes. The software pending bit can be written; the timer and external pending bits simply follow their lines.

Top module: `core_irq_cause`

## Requirements
- R1: After reset the enable word and the software pending bit are zero, irqReq is 0 and causeOut is all zeros.
- R2: A write with regSel=0 loads the enable word. Only bit 1 (software), bit 5 (timer) and bit 9 (external) are stored. With regSel=0, regRdData returns those three bits and zeros everywhere else.
- R3: With regSel=1, regRdData returns the pending word: bit 1 is the software pending latch, bit 5 follows tmrLine and bit 9 follows extLine, with all other bits zero. A write with regSel=1 changes only bit 1.
- R4: swLine high sets the software pending bit, and the bit stays set after the line falls until software writes 0 to bit 1. If swLine is high in the same cycle as that write, the set wins.
- R5: irqReq rises on the clock edge after any source becomes pending and enabled while globalEn is 1. It is 0 on the edge after globalEn is 0, and it is 0 on the edge after no source is pending and enabled.
- R6: A qualifying source gives a causeOut with bit XLEN-1 set and the code 1, 5 or 9 in bits 3:0, all other bits zero. When no source is pending and enabled, causeOut is all zeros.
- R7: When several sources are pending and enabled, external (code 9) outranks software (code 1), and software outranks timer (code 5).
- R8: Clearing a source's enable bit drops irqReq within two edges. That source's pending bit still reads as set.
- R9: causeOut is constant while irqReq stays 1. If the source being reported stops qualifying while others still do, irqReq goes 0 for one cycle, then returns with the new cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| swLine | input | 1 | Software (inter-processor) interrupt line |
| tmrLine | input | 1 | Timer interrupt line |
| extLine | input | 1 | External interrupt line from the platform controller |
| globalEn | input | 1 | Global interrupt enable |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the enable word, 1 selects the pending word |
| regWrData | input | XLEN | Register write data |
| regRdData | output | XLEN | Combinational read of the selected word |
| irqReq | output | 1 | Interrupt request to the core |
| causeOut | output | XLEN | Trap cause word |

## Verification
The hardest case to reach from the ports is a change of the reported source while the request is already held. This needs one source latched as the reported cause, a higher-ranked source arriving while the request is still up, and then the first source going away while the second remains. The stimulus gets there by holding the timer line with all enables set and adding the external line. It then checks that the cause stays at 5, that dropping the timer line gives exactly one idle cycle with the cause already 9, and that the request then returns. The vector walk holds globalEn low for two cycles before each check, so a latched software pending bit is in place before ranking is judged.

// File: rtl/core_irq_pkg.sv
package core_irq_pkg;

  localparam int NUM_SRC = 3;
  localparam int CODE_W  = 4;

  // Source index order: 0 software, 1 timer, 2 external
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_SW   = 2'd1,
    SRC_TMR  = 2'd2,
    SRC_EXT  = 2'd3
  } srcSel_e;

  typedef struct packed {
    logic    loadCause;
    srcSel_e winSel;
    logic    wrEnable;
    logic    wrPending;
  } ctrlStrb_t;

  // Cause code and enable bit position of source idx: 1, 5, 9
  function automatic int srcCode(input int idx);
    return 1 + 4 * idx;
  endfunction

endpackage

// File: rtl/core_irq_dp.sv
module core_irq_dp
  import core_irq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrb_t            strb,
  input  logic [XLEN-1:0]      regWrData,
  input  logic                 regSel,
  input  logic                 swLine,
  input  logic                 tmrLine,
  input  logic                 extLine,
  output logic [NUM_SRC-1:0]   actVec,
  output logic [XLEN-1:0]      regRdData,
  output logic [XLEN-1:0]      causeOut
);

  localparam int SW_POS = srcCode(0);

  logic [NUM_SRC-1:0] enBits;
  logic [NUM_SRC-1:0] pendVec;
  logic               swPend;
  logic [XLEN-1:0]    enWord;
  logic [XLEN-1:0]    pendWord;
  logic               unusedWrBits;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_en
      localparam int POS = srcCode(gi);
      always_ff @(posedge clk) begin
        if (!rstN)
          enBits[gi] <= 1'b0;
        else if (strb.wrEnable)
          enBits[gi] <= regWrData[POS];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)
      swPend <= 1'b0;
    else if (swLine)
      swPend <= 1'b1;
    else if (strb.wrPending)
      swPend <= regWrData[SW_POS];
  end

  assign pendVec = {extLine, tmrLine, swPend};
  assign actVec  = pendVec & enBits;

  always_comb begin
    enWord   = '0;
    pendWord = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      enWord[srcCode(i)]   = enBits[i];
      pendWord[srcCode(i)] = pendVec[i];
    end
  end

  assign regRdData = regSel ? pendWord : enWord;

  function automatic logic [XLEN-1:0] encodeCause(input srcSel_e sel);
    logic [CODE_W-1:0] code;
    case (sel)
      SRC_SW:  code = 4'd1;
      SRC_TMR: code = 4'd5;
      SRC_EXT: code = 4'd9;
      default: code = 4'd0;
    endcase
    if (sel == SRC_NONE)
      return '0;
    return {1'b1, {(XLEN-1-CODE_W){1'b0}}, code};
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN)
      causeOut <= '0;
    else if (strb.loadCause)
      causeOut <= encodeCause(strb.winSel);
  end

  assign unusedWrBits = ^regWrData;

endmodule

// File: rtl/core_irq_ctrl.sv
module core_irq_ctrl
  import core_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] actVec,
  input  logic               globalEn,
  input  logic               regWrEn,
  input  logic               regSel,
  output ctrlStrb_t          strb,
  output logic               irqReq
);

  srcSel_e heldSel;
  srcSel_e winner;
  logic    heldActive;
  logic    keep;
  logic    irqNext;

  // Rank: external, then software, then timer
  always_comb begin
    if (actVec[2])      winner = SRC_EXT;
    else if (actVec[0]) winner = SRC_SW;
    else if (actVec[1]) winner = SRC_TMR;
    else                winner = SRC_NONE;
  end

  always_comb begin
    case (heldSel)
      SRC_SW:  heldActive = actVec[0];
      SRC_TMR: heldActive = actVec[1];
      SRC_EXT: heldActive = actVec[2];
      default: heldActive = 1'b0;
    endcase
  end

  assign keep    = irqReq && heldActive && globalEn;
  assign irqNext = (|actVec) && globalEn && !(irqReq && !heldActive);

  assign strb.loadCause = !keep;
  assign strb.winSel    = winner;
  assign strb.wrEnable  = regWrEn && !regSel;
  assign strb.wrPending = regWrEn && regSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqReq  <= 1'b0;
      heldSel <= SRC_NONE;
    end else begin
      irqReq <= irqNext;
      if (!keep)
        heldSel <= winner;
    end
  end

endmodule

// File: rtl/core_irq_cause.sv
module core_irq_cause
  import core_irq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            swLine,
  input  logic            tmrLine,
  input  logic            extLine,
  input  logic            globalEn,
  input  logic            regWrEn,
  input  logic            regSel,
  input  logic [XLEN-1:0] regWrData,
  output logic [XLEN-1:0] regRdData,
  output logic            irqReq,
  output logic [XLEN-1:0] causeOut
);

  ctrlStrb_t          strb;
  logic [NUM_SRC-1:0] actVec;

  core_irq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .actVec   (actVec),
    .globalEn (globalEn),
    .regWrEn  (regWrEn),
    .regSel   (regSel),
    .strb     (strb),
    .irqReq   (irqReq)
  );

  core_irq_dp #(.XLEN(XLEN)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regWrData (regWrData),
    .regSel    (regSel),
    .swLine    (swLine),
    .tmrLine   (tmrLine),
    .extLine   (extLine),
    .actVec    (actVec),
    .regRdData (regRdData),
    .causeOut  (causeOut)
  );

endmodule

// File: rtl/core_irq_cause_chk.sv
module core_irq_cause_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            globalEn,
  input logic            irqReq,
  input logic [XLEN-1:0] causeOut,
  input logic [2:0]      actVec
);

  assert_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |=> !irqReq);

  assert_idle_no_req_R5: assert property (@(posedge clk) disable iff (!rstN)
    (actVec == 3'b000) |=> !irqReq);

  assert_cause_form_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (causeOut[XLEN-1] && causeOut[XLEN-2:4] == '0 &&
                (causeOut[3:0] == 4'd1 || causeOut[3:0] == 4'd5 ||
                 causeOut[3:0] == 4'd9)));

  assert_ext_first_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(irqReq) && $past(actVec[2])) |-> (causeOut[3:0] == 4'd9));

  assert_cause_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && $past(irqReq)) |-> (causeOut == $past(causeOut)));

endmodule

bind core_irq_cause core_irq_cause_chk #(.XLEN(XLEN)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .globalEn (globalEn),
  .irqReq   (irqReq),
  .causeOut (causeOut),
  .actVec   (actVec)
);

// File: tb/sim_core_irq_cause.sv
module sim_core_irq_cause;

  localparam int XLEN = 32;
  localparam int NVEC = 10;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            swLine = 1'b0;
  logic            tmrLine = 1'b0;
  logic            extLine = 1'b0;
  logic            globalEn = 1'b0;
  logic            regWrEn = 1'b0;
  logic            regSel = 1'b0;
  logic [XLEN-1:0] regWrData = '0;
  logic [XLEN-1:0] regRdData;
  logic            irqReq;
  logic [XLEN-1:0] causeOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  core_irq_cause #(.XLEN(XLEN)) u0 (
    .clk(clk), .rstN(rstN), .swLine(swLine), .tmrLine(tmrLine),
    .extLine(extLine), .globalEn(globalEn), .regWrEn(regWrEn),
    .regSel(regSel), .regWrData(regWrData), .regRdData(regRdData),
    .irqReq(irqReq), .causeOut(causeOut)
  );

  // [11:9] enable {ext,tmr,sw}, [8] sw, [7] tmr, [6] ext, [5] globalEn,
  // [4] expected irqReq, [3:0] expected cause code (0 = all-zero cause)
  localparam logic [11:0] VECS [NVEC] = '{
    12'b111_1_0_0_1_1_0001,
    12'b111_0_1_0_1_1_0101,
    12'b111_0_0_1_1_1_1001,
    12'b111_1_1_1_1_1_1001,
    12'b111_1_1_0_1_1_0001,
    12'b011_1_1_1_1_1_0001,
    12'b000_1_1_1_1_0_0000,
    12'b111_1_1_1_0_0_1001,
    12'b111_0_0_0_1_0_0000,
    12'b100_1_1_0_1_0_0000
  };

  function automatic logic [XLEN-1:0] expCause(input logic [3:0] code);
    if (code == 4'd0) return '0;
    return {1'b1, {(XLEN-5){1'b0}}, code};
  endfunction

  task automatic check(input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic regWrite(input logic sel, input logic [XLEN-1:0] data);
    regWrEn = 1'b1;
    regSel = sel;
    regWrData = data;
    step();
    regWrEn = 1'b0;
    regWrData = '0;
  endtask

  task automatic regRead(input logic sel, output logic [XLEN-1:0] data);
    regSel = sel;
    #1;
    data = regRdData;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog R5 actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [XLEN-1:0] rd;
    logic [11:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 irqReq", 64'(irqReq), 64'd0);
    check("R1 causeOut", 64'(causeOut), 64'd0);
    regRead(1'b0, rd); check("R1 enable word", 64'(rd), 64'd0);
    regRead(1'b1, rd); check("R1 pending word", 64'(rd), 64'd0);

    // Vector walk: R5 R6 R7 R8
    for (int k = 0; k < NVEC; k++) begin
      v = VECS[k];
      globalEn = 1'b0; swLine = 1'b0; tmrLine = 1'b0; extLine = 1'b0;
      regWrite(1'b1, '0);
      regWrite(1'b0, (XLEN'(v[9]) << 1) | (XLEN'(v[10]) << 5) |
                     (XLEN'(v[11]) << 9));
      swLine = v[8]; tmrLine = v[7]; extLine = v[6];
      step();
      step();
      globalEn = v[5];
      step();
      check($sformatf("R5 R7 vec%0d irqReq", k), 64'(irqReq), 64'(v[4]));
      check($sformatf("R6 R7 vec%0d causeOut", k), 64'(causeOut),
            64'(expCause(v[3:0])));
    end
    globalEn = 1'b0; swLine = 1'b0; tmrLine = 1'b0; extLine = 1'b0;
    regWrite(1'b1, '0);

    // R2 enable word keeps only bits 1, 5, 9
    regWrite(1'b0, '1);
    regRead(1'b0, rd); check("R2 enable all-ones", 64'(rd), 64'h222);
    regWrite(1'b0, 32'h0000_0200);
    regRead(1'b0, rd); check("R2 enable ext only", 64'(rd), 64'h200);

    // R3 pending word
    regWrite(1'b1, '1);
    regRead(1'b1, rd); check("R3 pend sw written", 64'(rd), 64'h002);
    tmrLine = 1'b1;
    regRead(1'b1, rd); check("R3 pend tmr line", 64'(rd), 64'h022);
    extLine = 1'b1;
    regRead(1'b1, rd); check("R3 pend ext line", 64'(rd), 64'h222);
    regWrite(1'b1, '0);
    regRead(1'b1, rd); check("R3 write clears only sw", 64'(rd), 64'h220);
    tmrLine = 1'b0; extLine = 1'b0;

    // R4 line set beats a clearing write, then latch holds
    swLine = 1'b1;
    regWrite(1'b1, '0);
    swLine = 1'b0;
    step();
    regRead(1'b1, rd); check("R4 sw latched over write", 64'(rd), 64'h002);
    regWrite(1'b1, '0);
    regRead(1'b1, rd); check("R4 sw cleared by write", 64'(rd), 64'h000);

    // R8 clearing the enable stops the request, pending kept
    regWrite(1'b0, 32'h0000_0020);
    tmrLine = 1'b1; globalEn = 1'b1;
    step();
    check("R8 tmr request up", 64'(irqReq), 64'd1);
    check("R8 tmr cause", 64'(causeOut), 64'(expCause(4'd5)));
    regWrite(1'b0, '0);
    step();
    check("R8 request dropped", 64'(irqReq), 64'd0);
    regRead(1'b1, rd); check("R8 tmr still pending", 64'(rd), 64'h020);
    regWrite(1'b0, 32'h0000_0020);
    step();
    check("R8 re-enabled request", 64'(irqReq), 64'd1);

    // R9 held cause, then handover with one idle cycle
    regWrite(1'b0, 32'h0000_0222);
    check("R9 held after enable write", 64'(causeOut), 64'(expCause(4'd5)));
    extLine = 1'b1;
    step();
    check("R9 ext arrives irqReq", 64'(irqReq), 64'd1);
    check("R9 ext arrives cause held", 64'(causeOut), 64'(expCause(4'd5)));
    tmrLine = 1'b0;
    step();
    check("R9 gap irqReq", 64'(irqReq), 64'd0);
    check("R9 gap cause", 64'(causeOut), 64'(expCause(4'd9)));
    step();
    check("R9 return irqReq", 64'(irqReq), 64'd1);
    check("R9 return cause", 64'(causeOut), 64'(expCause(4'd9)));

    // R5 global enable gating
    globalEn = 1'b0;
    step();
    check("R5 global off", 64'(irqReq), 64'd0);
    globalEn = 1'b1;
    step();
    check("R5 global on", 64'(irqReq), 64'd1);
    extLine = 1'b0;
    step();
    check("R6 nothing pending irqReq", 64'(irqReq), 64'd0);
    check("R6 nothing pending cause", 64'(causeOut), 64'd0);

    finishRun();
  end

endmodule